// File: doc/BRIEF.md
# Supervisor/User Privilege Checker

This block owns the status register (SR) of a processor core and decides, instruction by instruction, whether the core may do what it asks. The SR holds a mode flag, the supervisor bit. When the flag is set the core is in supervisor mode, and when it is clear the core is in user mode. The decode stage presents one instruction class per cycle with an issue strobe. The checker then lets the instruction take effect, or it refuses the instruction and raises a one-cycle privilege-violation strobe.

Exception entry can come from three places: an external exception strobe, a trap instruction, or a refused instruction. On entry the block hands out the old SR value with a push request so that it can be stacked. In the same clock edge it forces the supervisor bit. The supervisor bit can only be cleared by a privileged SR write or by a return-from-exception, and only when the core is already in supervisor mode.

Every bus cycle gets a transfer-modifier tag that marks it as a supervisor or a user reference. A stack-select output tells the stack-pointer file which stack pointer is active. All outputs are registered. They reflect the inputs that were sampled at the previous rising clock edge.

Top module: `priv_guard`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `sup_mode` is 1, `sr_value` holds only the supervisor bit (bit 13 set, others 0), `tm` is 2'b10, `sp_sup` is 1, and `priv_viol`, `sr_push`, `stop_go` and `reset_go` are 0.
- R2: `tm` is 2'b10 (supervisor reference) when the supervisor bit is set and 2'b01 (user reference) when it is clear. `sp_sup` equals the supervisor bit, and `sup_mode` equals bit 13 of `sr_value`.
- R3: A stop (class 1) or reset (class 2) instruction issued in user mode raises `priv_viol` for one cycle. `stop_go` and `reset_go` then stay 0.
- R4: A stop or reset instruction issued in supervisor mode pulses `stop_go` or `reset_go` respectively, and the SR is left unchanged.
- R5: An SR write (class 3) issued in supervisor mode loads all of `sr_wdata` into the SR. Issued in user mode, it raises `priv_viol` and the written value is discarded.
- R6: A return-from-exception (class 4) issued in supervisor mode loads the SR from the stacked value on `sr_wdata`, which may clear the supervisor bit. Issued in user mode, it raises `priv_viol` and the value is discarded.
- R7: A trap (class 5) is allowed in both modes and enters exception processing.
- R8: On any exception entry, `sr_push` pulses with `sr_push_data` equal to the SR before entry. In the same cycle the SR becomes that old value with the supervisor bit set.
- R9: A privilege violation is itself an exception entry. The old SR, with the supervisor bit clear, is pushed, and the core is in supervisor mode from that cycle on.
- R10: `exc_in` enters exception processing and has priority over an instruction issued in the same cycle. That instruction is discarded: no violation, no SR load, no stop or reset.
- R11: A normal instruction (class 0), class codes 6 and 7, and cycles without `issue` leave the SR unchanged and raise no strobe.
- R12: The supervisor bit never falls except one cycle after a class 3 or class 4 instruction that was issued in supervisor mode and not overridden by `exc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is presented this cycle |
| iclass | input | 3 | Instruction class: 0 normal, 1 stop, 2 reset, 3 SR write, 4 return-from-exception, 5 trap |
| sr_wdata | input | 16 | New SR for class 3, stacked SR for class 4 |
| exc_in | input | 1 | External exception-entry strobe |
| sup_mode | output | 1 | Current supervisor bit |
| sr_value | output | 16 | Current SR |
| priv_viol | output | 1 | Privilege-violation strobe |
| sr_push | output | 1 | Request to stack the old SR |
| sr_push_data | output | 16 | SR value to be stacked |
| stop_go | output | 1 | Stop instruction accepted |
| reset_go | output | 1 | Reset instruction accepted |
| tm | output | 2 | Transfer modifier: 2'b10 supervisor, 2'b01 user |
| sp_sup | output | 1 | Supervisor stack pointer active |

## Verification
The bench sweeps every instruction class, including the unused codes 6 and 7. Each class is tried in both modes, with and without a simultaneous exception strobe, and with several SR data patterns. The user/supervisor split separates the refused instructions from the allowed ones. The exception strobe shows whether the instruction is discarded. The data patterns show which SR bits are loaded and which are merely preserved, and whether the supervisor bit comes from the written value or is forced. Each step is compared against a model built from the requirements. The model is checked for the SR, the push value, every strobe and the bus tag.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [2:0] {
    IC_NORMAL = 3'd0,
    IC_STOP   = 3'd1,
    IC_RESET  = 3'd2,
    IC_SRWR   = 3'd3,
    IC_RTE    = 3'd4,
    IC_TRAP   = 3'd5
  } iclass_e;

  localparam logic [1:0] TM_USER = 2'b01;
  localparam logic [1:0] TM_SUPV = 2'b10;

  typedef struct packed {
    logic needs_sup;   // refused in user mode
    logic loads_sr;    // replaces SR when allowed
    logic is_stop;
    logic is_reset;
    logic is_trap;
  } dec_t;
endpackage

// File: rtl/priv_decode.sv
module priv_decode
  import priv_pkg::*;
(
  input  logic       issue,
  input  logic [2:0] iclass,
  output dec_t       dec
);
  always_comb begin
    dec = '0;
    if (issue) begin
      unique case (iclass)
        IC_STOP:  begin dec.needs_sup = 1'b1; dec.is_stop  = 1'b1; end
        IC_RESET: begin dec.needs_sup = 1'b1; dec.is_reset = 1'b1; end
        IC_SRWR:  begin dec.needs_sup = 1'b1; dec.loads_sr = 1'b1; end
        IC_RTE:   begin dec.needs_sup = 1'b1; dec.loads_sr = 1'b1; end
        IC_TRAP:  dec.is_trap = 1'b1;
        default:  dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/priv_sr_reg.sv
module priv_sr_reg #(
  parameter int SRW  = 16,
  parameter int SBIT = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enter,
  input  logic           load,
  input  logic [SRW-1:0] wdata,
  output logic [SRW-1:0] sr_q,
  output logic [SRW-1:0] sr_d,
  output logic           push,
  output logic [SRW-1:0] push_data
);
  localparam logic [SRW-1:0] SR_RST  = SRW'(1) << SBIT;
  localparam logic [SRW-1:0] SUP_MSK = SRW'(1) << SBIT;

  always_comb begin
    sr_d = sr_q;
    if (enter)     sr_d = sr_q | SUP_MSK;
    else if (load) sr_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= SR_RST;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      sr_q <= sr_d;
      push <= enter;
      if (enter) push_data <= sr_q;
    end
  end

  // R8: stacked value is the SR held before entry
  a_r8_push_old: assert property (@(posedge clk) disable iff (rst)
    push |-> push_data == $past(sr_q));
  // R8: entry leaves supervisor bit set
  a_r8_sup_after: assert property (@(posedge clk) disable iff (rst)
    push |-> sr_q[SBIT]);
endmodule

// File: rtl/priv_tm_gen.sv
module priv_tm_gen
  import priv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sup_d,
  output logic [1:0] tm,
  output logic       sp_sup
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tm     <= TM_SUPV;
      sp_sup <= 1'b1;
    end else begin
      tm     <= sup_d ? TM_SUPV : TM_USER;
      sp_sup <= sup_d;
    end
  end

  a_r2_tm_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tm) && tm != 2'b00);
endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_pkg::*;
#(
  parameter int SRW  = 16,
  parameter int SBIT = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic [2:0]     iclass,
  input  logic [SRW-1:0] sr_wdata,
  input  logic           exc_in,
  output logic           sup_mode,
  output logic [SRW-1:0] sr_value,
  output logic           priv_viol,
  output logic           sr_push,
  output logic [SRW-1:0] sr_push_data,
  output logic           stop_go,
  output logic           reset_go,
  output logic [1:0]     tm,
  output logic           sp_sup
);
  dec_t           dec;
  logic [SRW-1:0] sr_q, sr_d;
  logic           cur_sup, viol, enter, load;

  priv_decode u_dec (.issue(issue), .iclass(iclass), .dec(dec));

  assign cur_sup = sr_q[SBIT];
  assign viol    = !exc_in && dec.needs_sup && !cur_sup;
  assign enter   = exc_in || dec.is_trap || viol;
  assign load    = !exc_in && dec.loads_sr && cur_sup;

  priv_sr_reg #(.SRW(SRW), .SBIT(SBIT)) u_sr (
    .clk(clk), .rst(rst), .enter(enter), .load(load), .wdata(sr_wdata),
    .sr_q(sr_q), .sr_d(sr_d), .push(sr_push), .push_data(sr_push_data)
  );

  priv_tm_gen u_tm (
    .clk(clk), .rst(rst), .sup_d(sr_d[SBIT]), .tm(tm), .sp_sup(sp_sup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_viol <= 1'b0;
      stop_go   <= 1'b0;
      reset_go  <= 1'b0;
    end else begin
      priv_viol <= viol;
      stop_go   <= !exc_in && cur_sup && dec.is_stop;
      reset_go  <= !exc_in && cur_sup && dec.is_reset;
    end
  end

  assign sr_value = sr_q;
  assign sup_mode = sr_q[SBIT];

  // R9: a refused instruction lands the core in supervisor mode with a push
  a_r9_viol_enters: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> sup_mode && sr_push && !sr_push_data[SBIT]);
  // R3: refused instructions never take effect
  a_r3_no_effect: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> !stop_go && !reset_go);
  // R2: bus tag tracks the mode bit
  a_r2_tm_match: assert property (@(posedge clk) disable iff (rst)
    tm == (sup_mode ? TM_SUPV : TM_USER) && sp_sup == sup_mode);
  // R12: supervisor bit only falls after an allowed SR load
  a_r12_fall_only_load: assert property (@(posedge clk) disable iff (rst)
    $fell(sup_mode) |-> $past(issue && !exc_in &&
      (iclass == 3'd3 || iclass == 3'd4)));
  // R4: accepted stop/reset only in supervisor mode, SR untouched
  a_r4_stop_sup: assert property (@(posedge clk) disable iff (rst)
    (stop_go || reset_go) |-> sup_mode && $stable(sr_value));
endmodule

// File: tb/test_priv_guard.sv
module test_priv_guard;
  localparam int SRW = 16;
  localparam int SB  = 13;

  logic           clk = 1'b0;
  logic           rst;
  logic           issue;
  logic [2:0]     iclass;
  logic [SRW-1:0] sr_wdata;
  logic           exc_in;
  logic           sup_mode, priv_viol, sr_push, stop_go, reset_go, sp_sup;
  logic [SRW-1:0] sr_value, sr_push_data;
  logic [1:0]     tm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [SRW-1:0] m_sr;

  always #10 clk = ~clk;

  priv_guard #(.SRW(SRW), .SBIT(SB)) i_priv_guard (
    .clk(clk), .rst(rst), .issue(issue), .iclass(iclass), .sr_wdata(sr_wdata),
    .exc_in(exc_in), .sup_mode(sup_mode), .sr_value(sr_value),
    .priv_viol(priv_viol), .sr_push(sr_push), .sr_push_data(sr_push_data),
    .stop_go(stop_go), .reset_go(reset_go), .tm(tm), .sp_sup(sp_sup)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic iss, input logic [2:0] cls,
                      input logic [SRW-1:0] wd, input logic ex, input string req);
    logic s, viol, ent, ld, e_push, e_stop, e_rst;
    logic [SRW-1:0] e_pdata;
    @(negedge clk);
    issue = iss; iclass = cls; sr_wdata = wd; exc_in = ex;
    s      = m_sr[SB];
    viol   = iss && !ex && !s && (cls >= 3'd1 && cls <= 3'd4);
    ent    = ex || (iss && cls == 3'd5) || viol;
    ld     = iss && !ex && s && (cls == 3'd3 || cls == 3'd4);
    e_push = ent;
    e_pdata = m_sr;
    e_stop = iss && !ex && s && cls == 3'd1;
    e_rst  = iss && !ex && s && cls == 3'd2;
    if (ent) m_sr[SB] = 1'b1;
    else if (ld) m_sr = wd;
    @(negedge clk);
    issue = 1'b0; exc_in = 1'b0;
    chk({req, " sr"}, 32'(sr_value), 32'(m_sr));
    chk({req, " R3 viol"}, 32'(priv_viol), 32'(viol));
    chk({req, " R8 push"}, 32'(sr_push), 32'(e_push));
    if (e_push) chk({req, " R8 pdata"}, 32'(sr_push_data), 32'(e_pdata));
    chk({req, " R4 stop"}, 32'(stop_go), 32'(e_stop));
    chk({req, " R4 reset"}, 32'(reset_go), 32'(e_rst));
    chk({req, " R2 tm"}, 32'(tm), m_sr[SB] ? 32'd2 : 32'd1);
    chk({req, " R2 sp"}, 32'(sp_sup), 32'(m_sr[SB]));
    chk({req, " R2 mode"}, 32'(sup_mode), 32'(m_sr[SB]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [SRW-1:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'h2000; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;
    rst = 1'b1; issue = 1'b0; iclass = '0; sr_wdata = '0; exc_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 sr", 32'(sr_value), 32'h2000);
    chk("R1 mode", 32'(sup_mode), 32'd1);
    chk("R1 tm", 32'(tm), 32'd2);
    chk("R1 sp", 32'(sp_sup), 32'd1);
    chk("R1 strobes", {28'd0, priv_viol, sr_push, stop_go, reset_go}, 32'd0);
    rst = 1'b0;
    m_sr = 16'h2000;
    step(1'b0, 3'd0, 16'h0000, 1'b0, "R1 first");
    for (int mode = 0; mode < 2; mode++)
      for (int c = 0; c < 8; c++)
        for (int ex = 0; ex < 2; ex++)
          for (int p = 0; p < 4; p++) begin
            // set up mode: from supervisor, write SR with chosen bit
            if (!m_sr[SB]) step(1'b0, 3'd0, '0, 1'b1, "R10 setup");
            step(1'b1, 3'd3, (pats[p] & ~16'h2000) | (mode ? 16'h2000 : 16'h0),
                 1'b0, "R5 setup");
            step(1'b1, 3'(c), pats[(p + 1) % 4], ex[0],
                 c == 5 ? "R7 trap" : c == 4 ? "R6 rte" : c == 3 ? "R5 srwr" :
                 ex ? "R10 exc" : (c >= 6 || c == 0) ? "R11 normal" :
                 mode ? "R4 priv" : "R9 viol");
            step(1'b0, 3'(c), 16'hFFFF, 1'b0, "R11 idle");
          end
    // R12: return-from-exception to user mode then user trap back
    step(1'b1, 3'd4, 16'h0013, 1'b0, "R12 rte user");
    step(1'b1, 3'd5, 16'hFFFF, 1'b0, "R7 user trap");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule